// File: doc/BRIEF.md
# Per-Algorithm Prescale and Masked Final Trigger Decision

This block sits at the end of a trigger decision chain. In every bunch crossing it receives a vector of algorithm bits. Each bit was formed upstream from condition bits. Every algorithm bit passes through a prescaler of its own, which lets through only every Nth true occurrence. A saturating counter for that algorithm counts the bits that pass. The surviving bits are gated by an enable mask and OR-reduced into a one-bit accept. A second mask picks algorithm bits that act as vetoes; when any of them is set, the accept is forced low.

Crossings arrive as a plain stream: `bx_valid` marks a cycle that carries a crossing. The block has no ready signal and never applies back-pressure, so every flagged crossing is consumed in its own cycle. Masks and prescale factors are loaded through a simple write port. The per-algorithm counts are read back through an index/data pair.

Top module: `algo_final_or`

## Requirements
- R1: `accept` is registered and reflects the crossing presented one clock earlier. In a cycle after one with `bx_valid` low, `accept` is 0.
- R2: With no veto active, `accept` is 1 exactly when at least one algorithm bit that passed its prescaler has its enable-mask bit set.
- R3: If any raw (unprescaled) algorithm bit is set whose veto-mask bit is set, `accept` is 0 for that crossing, whatever the enable mask says.
- R4: With prescale factor N ≥ 1, an algorithm passes on the Nth, 2Nth, ... true occurrence counted since reset or clear. N = 1 passes every occurrence.
- R5: Prescale factor 0 blocks the algorithm completely and freezes its prescaler phase.
- R6: Each algorithm's counter adds one for every prescaled pass, whether or not that algorithm is enabled or vetoed.
- R7: A counter that reaches its all-ones value stays there until it is cleared.
- R8: Writing 1 to bit 0 of the control register zeroes all counters and all prescaler phases at that clock edge. A crossing in the same cycle is not counted.
- R9: A register write takes effect for the crossing in the following cycle. A crossing in the same cycle as the write still uses the old settings.
- R10: The address map, with W = ceil(N_ALGO/REG_W), is: enable-mask words at 0..W-1, veto-mask words at W..2W-1, and the prescale factor for algorithm i at 2W+i in the low PS_W bits. The control register is at 2W+N_ALGO. Bit b of mask word w belongs to algorithm w*REG_W+b. Writes to any other address change nothing.
- R11: After reset, both masks are all zero, so no crossing gives an accept. All prescale factors are 1 and all counters read 0.
- R12: `rd_cnt` shows the counter selected by `rd_idx` one clock later. An index at or beyond N_ALGO reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bx_valid | input | 1 | Current cycle carries a crossing |
| algo_bits | input | N_ALGO | Algorithm bits of the crossing |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register write address |
| cfg_wdata | input | REG_W | Register write data |
| rd_idx | input | IDX_W | Counter index to read |
| rd_cnt | output | CNT_W | Selected counter value, one cycle late |
| accept | output | 1 | Final trigger decision, one cycle late |

## Verification
The bench builds the block with 40 algorithms and 32-bit register words. This gives two mask words, the second one only partly filled, so the word split and the bit mapping across words are both exercised. The counters are 4 bits wide, so saturation is reached after 15 passes. The read index is 6 bits wide, so indices beyond the last algorithm can be driven to check that they read 0. The prescale field is 8 bits wide, which is enough for a factor of 3 and for the blocking factor 0.

// File: rtl/algo_fo_pkg.sv
package algo_fo_pkg;
  typedef enum logic [2:0] {
    SEL_EN,
    SEL_VETO,
    SEL_PS,
    SEL_CTRL,
    SEL_NONE
  } reg_sel_e;

  function automatic int unsigned mask_words(int unsigned n, int unsigned w);
    return (n + w - 1) / w;
  endfunction

  function automatic int unsigned map_span(int unsigned n, int unsigned w);
    return 2 * mask_words(n, w) + n + 1;
  endfunction
endpackage

// File: rtl/algo_cfg_regs.sv
module algo_cfg_regs
  import algo_fo_pkg::*;
#(
  parameter int N_ALGO = 128,
  parameter int REG_W  = 32,
  parameter int PS_W   = 16,
  parameter int AW     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [AW-1:0]                addr,
  input  logic [REG_W-1:0]             wdata,
  output logic [N_ALGO-1:0]            en_mask,
  output logic [N_ALGO-1:0]            veto_mask,
  output logic [N_ALGO-1:0][PS_W-1:0]  ps_fac,
  output logic                         clr
);
  localparam int NW      = int'(mask_words(N_ALGO, REG_W));
  localparam int PS_BASE = 2 * NW;
  localparam int CTRL_A  = PS_BASE + N_ALGO;

  reg_sel_e sel;
  int       a;

  always_comb begin
    a = int'(addr);
    if (a < NW)               sel = SEL_EN;
    else if (a < PS_BASE)     sel = SEL_VETO;
    else if (a < CTRL_A)      sel = SEL_PS;
    else if (a == CTRL_A)     sel = SEL_CTRL;
    else                      sel = SEL_NONE;
  end

  assign clr = we && (sel == SEL_CTRL) && wdata[0];

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int LO = w * REG_W;
    localparam int NB = (N_ALGO - LO < REG_W) ? (N_ALGO - LO) : REG_W;
    always_ff @(posedge clk) begin
      if (rst) begin
        en_mask[LO +: NB]   <= '0;
        veto_mask[LO +: NB] <= '0;
      end else if (we) begin
        if (sel == SEL_EN && a == w)         en_mask[LO +: NB]   <= wdata[NB-1:0];
        if (sel == SEL_VETO && a == NW + w)  veto_mask[LO +: NB] <= wdata[NB-1:0];
      end
    end
  end

  for (genvar i = 0; i < N_ALGO; i++) begin : g_ps
    always_ff @(posedge clk) begin
      if (rst)                                          ps_fac[i] <= PS_W'(1);
      else if (we && sel == SEL_PS && a == PS_BASE + i) ps_fac[i] <= wdata[PS_W-1:0];
    end
  end
endmodule

// File: rtl/algo_prescaler.sv
module algo_prescaler #(
  parameter int PS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            hit,
  input  logic [PS_W-1:0] factor,
  output logic            pass
);
  logic [PS_W-1:0] phase;
  logic            live;

  assign live = hit && (factor != '0);
  assign pass = live && (phase >= factor - PS_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)  phase <= '0;
    else if (pass)   phase <= '0;
    else if (live)   phase <= phase + PS_W'(1);
  end
endmodule

// File: rtl/algo_counter.sv
module algo_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (inc && cnt != '1)  cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/algo_final_or.sv
module algo_final_or
  import algo_fo_pkg::*;
#(
  parameter int N_ALGO = 128,
  parameter int REG_W  = 32,
  parameter int PS_W   = 16,
  parameter int CNT_W  = 32,
  parameter int AW     = $clog2(int'(map_span(N_ALGO, REG_W))),
  parameter int IDX_W  = $clog2(N_ALGO)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bx_valid,
  input  logic [N_ALGO-1:0] algo_bits,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic              accept
);
  logic [N_ALGO-1:0]             en_mask, veto_mask, pass;
  logic [N_ALGO-1:0][PS_W-1:0]   ps_fac;
  logic [N_ALGO-1:0][CNT_W-1:0]  cnt_all;
  logic                          clr;

  algo_cfg_regs #(.N_ALGO(N_ALGO), .REG_W(REG_W), .PS_W(PS_W), .AW(AW)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en_mask(en_mask), .veto_mask(veto_mask), .ps_fac(ps_fac), .clr(clr)
  );

  for (genvar i = 0; i < N_ALGO; i++) begin : g_algo
    algo_prescaler #(.PS_W(PS_W)) ps_i (
      .clk(clk), .rst(rst), .clr(clr), .hit(bx_valid && algo_bits[i]),
      .factor(ps_fac[i]), .pass(pass[i])
    );
    algo_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst(rst), .clr(clr), .inc(pass[i]), .cnt(cnt_all[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accept <= 1'b0;
      rd_cnt <= '0;
    end else begin
      accept <= bx_valid && (|(pass & en_mask)) && !(|(algo_bits & veto_mask));
      rd_cnt <= (int'(rd_idx) < N_ALGO) ? cnt_all[rd_idx] : '0;
    end
  end
endmodule

// File: rtl/algo_final_or_chk.sv
module algo_final_or_chk #(
  parameter int N_ALGO = 128,
  parameter int PS_W   = 16,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         bx_valid,
  input logic [N_ALGO-1:0]            algo_bits,
  input logic [N_ALGO-1:0]            en_mask,
  input logic [N_ALGO-1:0]            veto_mask,
  input logic [N_ALGO-1:0]            pass,
  input logic [N_ALGO-1:0][PS_W-1:0]  ps_fac,
  input logic [N_ALGO-1:0][CNT_W-1:0] cnt_all,
  input logic                         clr,
  input logic                         accept
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !bx_valid |=> !accept);

  p_enabled_fires_r2: assert property (@(posedge clk) disable iff (rst)
    (bx_valid && |(pass & en_mask) && !(|(algo_bits & veto_mask))) |=> accept);

  p_nothing_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    (bx_valid && !(|(pass & en_mask))) |=> !accept);

  p_veto_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (bx_valid && |(algo_bits & veto_mask)) |=> !accept);

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_all == '0));

  for (genvar i = 0; i < N_ALGO; i++) begin : g_chk
    p_zero_blocks_r5: assert property (@(posedge clk) disable iff (rst)
      (ps_fac[i] == '0) |-> !pass[i]);

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
      (pass[i] && !clr && cnt_all[i] != '1) |=> cnt_all[i] == CNT_W'($past(cnt_all[i]) + 1'b1));

    p_sat_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (cnt_all[i] == '1 && !clr) |=> cnt_all[i] == '1);
  end
endmodule

bind algo_final_or algo_final_or_chk #(.N_ALGO(N_ALGO), .PS_W(PS_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .bx_valid(bx_valid), .algo_bits(algo_bits),
  .en_mask(en_mask), .veto_mask(veto_mask), .pass(pass), .ps_fac(ps_fac),
  .cnt_all(cnt_all), .clr(clr), .accept(accept)
);

// File: tb/algo_final_or_tb_top.sv
module algo_final_or_tb_top;
  localparam int NA = 40, RW = 32, PW = 8, CW = 4, AW = 6, IW = 6;
  localparam int CTRL = 44;

  logic          clk = 1'b0, rst = 1'b1, bx_valid = 1'b0, cfg_we = 1'b0;
  logic [NA-1:0] algo_bits = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [CW-1:0] rd_cnt;
  logic          accept;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  algo_final_or #(.N_ALGO(NA), .REG_W(RW), .PS_W(PW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .bx_valid(bx_valid), .algo_bits(algo_bits),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_idx(rd_idx), .rd_cnt(rd_cnt), .accept(accept)
  );

  // {expected accept, algorithm bits}; enable = 0..3 and 35, veto = 5, prescale 1
  localparam logic [NA:0] VEC [9] = '{
    {1'b0, 40'h00_0000_0000}, {1'b1, 40'h00_0000_0001}, {1'b0, 40'h00_0000_0400},
    {1'b1, 40'h08_0000_0000}, {1'b0, 40'h00_0000_0021}, {1'b0, 40'h00_0000_0020},
    {1'b1, 40'h00_0000_0408}, {1'b0, 40'hFF_FFFF_FFFF}, {1'b0, 40'h80_0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [RW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic xing(input logic [NA-1:0] b, output logic acc);
    @(negedge clk); bx_valid = 1'b1; algo_bits = b;
    @(negedge clk); bx_valid = 1'b0; algo_bits = '0; acc = accept;
  endtask

  task automatic rdc(input int idx, output logic [CW-1:0] v);
    @(negedge clk); rd_idx = IW'(idx);
    @(negedge clk); v = rd_cnt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic acc;
    logic [CW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 accept after reset", accept, 0);
    rdc(0, v); chk("R11 counter after reset", v, 0);
    xing('1, acc); chk("R11 masks cleared", acc, 0);

    wr(0, 32'h0000_000F); wr(1, 32'h0000_0008); wr(2, 32'h0000_0020);
    wr(CTRL, 1);
    foreach (VEC[k]) begin
      xing(VEC[k][NA-1:0], acc);
      chk("R2/R3 table", acc, VEC[k][NA]);
    end
    @(negedge clk); chk("R1 idle cycle", accept, 0);

    wr(CTRL, 1);
    xing(40'h400, acc); chk("R6 disabled not accepted", acc, 0);
    xing(40'h400, acc);
    rdc(10, v); chk("R6 count regardless of mask", v, 2);
    rdc(50, v); chk("R12 out of range index", v, 0);

    wr(6, 3);
    for (int n = 1; n <= 7; n++) begin
      xing(40'h4, acc); chk("R4 every third", acc, (n % 3 == 0) ? 1 : 0);
    end
    rdc(2, v); chk("R4 prescaled count", v, 2);
    wr(CTRL, 1);
    xing(40'h4, acc); chk("R8 phase cleared 1", acc, 0);
    xing(40'h4, acc); chk("R8 phase cleared 2", acc, 0);
    xing(40'h4, acc); chk("R8 phase cleared 3", acc, 1);
    wr(CTRL, 1);

    wr(5, 0);
    for (int n = 0; n < 3; n++) begin
      xing(40'h2, acc); chk("R5 factor zero blocks", acc, 0);
    end
    rdc(1, v); chk("R5 no counts", v, 0);
    wr(5, 1);
    xing(40'h2, acc); chk("R5 unblocked", acc, 1);

    for (int n = 0; n < 17; n++) xing(40'h10_0000, acc);
    rdc(20, v); chk("R7 saturation", v, 15);

    @(negedge clk); bx_valid = 1'b1; algo_bits = 40'h10_0000;
    cfg_we = 1'b1; cfg_addr = AW'(CTRL); cfg_wdata = 1;
    @(negedge clk); bx_valid = 1'b0; algo_bits = '0; cfg_we = 1'b0;
    rdc(20, v); chk("R8 clear beats crossing", v, 0);

    @(negedge clk); bx_valid = 1'b1; algo_bits = 40'h400;
    cfg_we = 1'b1; cfg_addr = 0; cfg_wdata = 32'h0000_040F;
    @(negedge clk); bx_valid = 1'b0; algo_bits = '0; cfg_we = 1'b0;
    chk("R9 old settings same cycle", accept, 0);
    xing(40'h400, acc); chk("R9 new settings next crossing", acc, 1);

    wr(50, '1);
    xing(40'h200, acc); chk("R10 unmapped write no enable", acc, 0);
    xing(40'h21, acc);  chk("R10 unmapped write veto kept", acc, 0);
    xing(40'h1, acc);   chk("R10 enable bit0 kept", acc, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule